// File: doc/BRIEF.md
# SD Card Data Buffer with Level Thresholds

This block is the word buffer between a host register port and the data-line engine of an SD card host. It holds up to `DEPTH` words of `WIDTH` bits (16 words of 32 bits by default) and serves both transfer directions. A direction bit in the configuration register picks the roles. In card-to-host mode the engine fills the buffer and the host drains it through the data register. In host-to-card mode the host fills it through the data register and the engine drains it.

Software watches the buffer through a data-ready flag. In card-to-host mode the flag compares the fill level with a programmable drain threshold. In host-to-card mode it compares the free space with a programmable fill threshold. The flag can also drive an interrupt line through an enable bit. A host access that would overrun a full buffer or read an empty one does nothing except set a sticky error bit, which software clears by writing a 1 to it.

The engine side uses valid/ready streams. On the inbound stream (`eng_in_*`) a word is taken on any cycle where `eng_in_valid` and `eng_in_ready` are both high. `eng_in_ready` is high only in card-to-host mode while the buffer has room. On the outbound stream (`eng_out_*`) a word leaves on any cycle where `eng_out_valid` and `eng_out_ready` are both high. `eng_out_valid` is high only in host-to-card mode while the buffer holds data, and `eng_out_data` shows the oldest word. Because the engine waits on ready or valid, it can never overrun or underrun the buffer.

Top module: `sd_data_buf`

## Requirements
- R1: Words leave the buffer in the order they entered, and up to DEPTH words can be held at once.
- R2: The register port uses `reg_addr` 0 for data, 1 for status, 2 for configuration and 3 for the level/threshold register. The level/threshold register shows the current fill count (0..DEPTH, C = clog2(DEPTH+1) bits) at bits [4+C-1:4], which is bits 8:4 by default.
- R3: The fill threshold sits at bits [4+2C-1:4+C] (13:9 by default) and the drain threshold at bits [4+3C-1:4+2C] (18:14 by default). Both are writable, both reset to 4, and writes to the fill-count field are ignored.
- R4: With configuration bit 0 = 1 (card-to-host), status bit 0 is 1 exactly when fill count >= drain threshold.
- R5: With configuration bit 0 = 0 (host-to-card), status bit 0 is 1 exactly when DEPTH - fill count >= fill threshold.
- R6: `data_irq` equals status bit 0 AND configuration bit 4, and `data_flag` always mirrors status bit 0.
- R7: In card-to-host mode, a data-register read while empty returns 0, leaves the fill count unchanged and sets status bit 3. In host-to-card mode, a data-register write while full leaves the contents and count unchanged and sets status bit 3.
- R8: Status bit 3 is sticky. Writing the status register with bit 3 = 1 clears it, and writing 0 there leaves it set.
- R9: `eng_in_ready` = card-to-host mode AND count < DEPTH, and `eng_out_valid` = host-to-card mode AND count > 0. A word moves only when valid and ready are both high.
- R10: A data-register write in card-to-host mode, or a data-register read in host-to-card mode, has no effect. Such a read returns 0.
- R11: After reset the fill count is 0, status bit 3 is 0, configuration is 0 (host-to-card, interrupt disabled) and both thresholds are 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only at data address) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | WIDTH | Register write data |
| reg_rdata | output | WIDTH | Register read data, combinational from `reg_addr` |
| eng_in_valid | input | 1 | Engine offers a word |
| eng_in_ready | output | 1 | Buffer accepts an engine word |
| eng_in_data | input | WIDTH | Word from engine |
| eng_out_valid | output | 1 | Buffer offers a word to the engine |
| eng_out_ready | input | 1 | Engine accepts the word |
| eng_out_data | output | WIDTH | Oldest buffered word |
| data_flag | output | 1 | Threshold flag (status bit 0) |
| data_irq | output | 1 | Flag gated by interrupt enable |

## Verification
The bench builds the block with DEPTH = 8 and WIDTH = 16. That makes the count field 4 bits wide and moves the threshold fields to bits 11:8 and 15:12. With this size, every fill level from empty to full can be crossed with every threshold value from 0 to 8 in both directions. The full and empty edges are also reached cheaply, so overrun, underrun and engine back-pressure can each be driven at the exact boundary. Expected flags, field values and word contents are computed arithmetically from the level and threshold.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [1:0] {
    SDF_DATA = 2'd0,
    SDF_STAT = 2'd1,
    SDF_CFG  = 2'd2,
    SDF_LVL  = 2'd3
  } sdf_addr_e;

  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_ERR_BIT  = 3;
  localparam int CFG_DIR_BIT   = 0;
  localparam int CFG_IRQ_BIT   = 4;
  localparam int LVL_FILL_LSB  = 4;
endpackage

// File: rtl/sdf_storage.sv
module sdf_storage #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rd_ptr];

  // R2
  level_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + CW'(1)));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count != CW'(DEPTH)));
endmodule

// File: rtl/sdf_level.sv
module sdf_level #(
  parameter int DEPTH = 16
) (
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic                       dir_read,
  input  logic [$clog2(DEPTH+1)-1:0] drain_thr,
  input  logic [$clog2(DEPTH+1)-1:0] fill_thr,
  input  logic                       irq_en,
  output logic                       flag,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] space;

  always_comb begin
    space = CW'(DEPTH) - count;
    flag  = dir_read ? (count >= drain_thr) : (space >= fill_thr);
    irq   = flag && irq_en;
  end
endmodule

// File: rtl/sdf_regs.sv
module sdf_regs #(
  parameter int DEPTH     = 16,
  parameter int RESET_THR = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_dir_in,
  input  logic                       cfg_irq_in,
  input  logic                       lvl_we,
  input  logic [$clog2(DEPTH+1)-1:0] fill_thr_in,
  input  logic [$clog2(DEPTH+1)-1:0] drain_thr_in,
  input  logic                       stat_we,
  input  logic                       err_clr_bit,
  input  logic                       err_evt,
  output logic                       dir_read,
  output logic                       irq_en,
  output logic [$clog2(DEPTH+1)-1:0] fill_thr,
  output logic [$clog2(DEPTH+1)-1:0] drain_thr,
  output logic                       err
);
  localparam int CW = $clog2(DEPTH+1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_read  <= 1'b0;
      irq_en    <= 1'b0;
      fill_thr  <= CW'(RESET_THR);
      drain_thr <= CW'(RESET_THR);
      err       <= 1'b0;
    end else begin
      if (cfg_we) begin
        dir_read <= cfg_dir_in;
        irq_en   <= cfg_irq_in;
      end
      if (lvl_we) begin
        fill_thr  <= fill_thr_in;
        drain_thr <= drain_thr_in;
      end
      if (err_evt)                     err <= 1'b1;
      else if (stat_we && err_clr_bit) err <= 1'b0;
    end
  end

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err);
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && err_clr_bit && !err_evt) |=> !err);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(stat_we && err_clr_bit)) |=> err);
endmodule

// File: rtl/sd_data_buf.sv
module sd_data_buf #(
  parameter int WIDTH     = 32,
  parameter int DEPTH     = 16,
  parameter int RESET_THR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             eng_in_valid,
  output logic             eng_in_ready,
  input  logic [WIDTH-1:0] eng_in_data,
  output logic             eng_out_valid,
  input  logic             eng_out_ready,
  output logic [WIDTH-1:0] eng_out_data,
  output logic             data_flag,
  output logic             data_irq
);
  import sdf_pkg::*;

  localparam int CW     = $clog2(DEPTH+1);
  localparam int FILL_L = LVL_FILL_LSB;
  localparam int WTH_L  = LVL_FILL_LSB + CW;
  localparam int RTH_L  = LVL_FILL_LSB + 2*CW;

  logic [CW-1:0]    count, fill_thr, drain_thr;
  logic [WIDTH-1:0] head, push_data;
  logic             dir_read, irq_en, err;
  logic             full, empty, push, pop;
  logic             data_wr, data_rd, host_push, host_pop, err_evt;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  assign data_wr   = reg_wr && (reg_addr == SDF_DATA);
  assign data_rd   = reg_rd && (reg_addr == SDF_DATA);
  assign host_push = data_wr && !dir_read && !full;
  assign host_pop  = data_rd && dir_read && !empty;
  assign err_evt   = (data_wr && !dir_read && full) ||
                     (data_rd && dir_read && empty);

  assign eng_in_ready  = dir_read && !full;
  assign eng_out_valid = !dir_read && !empty;
  assign eng_out_data  = head;

  assign push      = dir_read ? (eng_in_valid && eng_in_ready) : host_push;
  assign push_data = dir_read ? eng_in_data : reg_wdata;
  assign pop       = dir_read ? host_pop : (eng_out_valid && eng_out_ready);

  sdf_storage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data), .pop(pop),
    .head(head), .count(count)
  );

  sdf_regs #(.DEPTH(DEPTH), .RESET_THR(RESET_THR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(reg_wr && (reg_addr == SDF_CFG)),
    .cfg_dir_in(reg_wdata[CFG_DIR_BIT]),
    .cfg_irq_in(reg_wdata[CFG_IRQ_BIT]),
    .lvl_we(reg_wr && (reg_addr == SDF_LVL)),
    .fill_thr_in(reg_wdata[WTH_L +: CW]),
    .drain_thr_in(reg_wdata[RTH_L +: CW]),
    .stat_we(reg_wr && (reg_addr == SDF_STAT)),
    .err_clr_bit(reg_wdata[STAT_ERR_BIT]),
    .err_evt(err_evt),
    .dir_read(dir_read), .irq_en(irq_en),
    .fill_thr(fill_thr), .drain_thr(drain_thr), .err(err)
  );

  sdf_level #(.DEPTH(DEPTH)) u_level (
    .count(count), .dir_read(dir_read),
    .drain_thr(drain_thr), .fill_thr(fill_thr), .irq_en(irq_en),
    .flag(data_flag), .irq(data_irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SDF_DATA: if (dir_read && !empty) reg_rdata = head;
      SDF_STAT: begin
        reg_rdata[STAT_FLAG_BIT] = data_flag;
        reg_rdata[STAT_ERR_BIT]  = err;
      end
      SDF_CFG: begin
        reg_rdata[CFG_DIR_BIT] = dir_read;
        reg_rdata[CFG_IRQ_BIT] = irq_en;
      end
      default: begin
        reg_rdata[FILL_L +: CW] = count;
        reg_rdata[WTH_L +: CW]  = fill_thr;
        reg_rdata[RTH_L +: CW]  = drain_thr;
      end
    endcase
  end

  // R9
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_in_ready && eng_out_valid));
  // R10
  wrong_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && dir_read && !(eng_in_valid && eng_in_ready)) |=> $stable(count));
endmodule

// File: tb/sd_data_buf_bench.sv
module sd_data_buf_bench;
  localparam int W  = 16;
  localparam int D  = 8;
  localparam int CW = 4;
  localparam int FL = 4;
  localparam int WL = 4 + CW;
  localparam int RL = 4 + 2*CW;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;
  logic eng_in_valid = 0, eng_in_ready;
  logic [W-1:0] eng_in_data = 0;
  logic eng_out_valid, eng_out_ready = 0;
  logic [W-1:0] eng_out_data;
  logic data_flag, data_irq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  sd_data_buf #(.WIDTH(W), .DEPTH(D), .RESET_THR(4)) u_sd_data_buf (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready), .eng_in_data(eng_in_data),
    .eng_out_valid(eng_out_valid), .eng_out_ready(eng_out_ready), .eng_out_data(eng_out_data),
    .data_flag(data_flag), .data_irq(data_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic int fill_of(input logic [W-1:0] v);
    return int'(v[FL +: CW]);
  endfunction

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    peek(2'd3, v); check("R11 lvl", int'(v), (4 << WL) | (4 << RL));
    peek(2'd2, v); check("R11 cfg", int'(v), 0);
    peek(2'd1, v); check("R11 stat", int'(v), 1);
    check("R11 irq", int'(data_irq), 0);
    check("R11 out_valid", int'(eng_out_valid), 0);
    check("R11 in_ready", int'(eng_in_ready), 0);

    // host-to-card sweep, irq enabled
    wr(2'd2, W'(16'h10));
    for (int f = 0; f <= D; f++) begin
      for (int t = 0; t <= D; t++) begin
        wr(2'd3, W'((t << WL) | (4 << RL)));
        peek(2'd1, v);
        check("R5 flag", int'(v[0]), int'((D - f) >= t));
        check("R6 irq", int'(data_irq), int'((D - f) >= t));
        check("R6 data_flag", int'(data_flag), int'(v[0]));
      end
      peek(2'd3, v); check("R2 fill", fill_of(v), f);
      check("R9 out_valid", int'(eng_out_valid), int'(f > 0));
      if (f < D) wr(2'd0, W'(16'hA000 + f));
    end
    // R7 overrun
    wr(2'd0, W'(16'hDEAD));
    peek(2'd3, v); check("R7 fill after overrun", fill_of(v), D);
    peek(2'd1, v); check("R7 err set", int'(v[3]), 1);
    // R8 write 0 keeps error
    wr(2'd1, W'(0));
    peek(2'd1, v); check("R8 err kept", int'(v[3]), 1);
    wr(2'd1, W'(8));
    peek(2'd1, v); check("R8 err cleared", int'(v[3]), 0);
    // R6 irq disabled
    wr(2'd2, W'(0));
    wr(2'd3, W'(0));
    check("R6 irq gated", int'(data_irq), 0);
    check("R6 flag still", int'(data_flag), 1);
    // R10 data read in host-to-card mode
    rd(2'd0, v); check("R10 read value", int'(v), 0);
    peek(2'd3, v); check("R10 no pop", fill_of(v), D);
    // R3 fill field write ignored
    wr(2'd3, W'((4'hF << FL) | (2 << WL) | (3 << RL)));
    peek(2'd3, v);
    check("R3 fill ignored", fill_of(v), D);
    check("R3 thresholds", int'(v[WL +: 2*CW]), 2 | (3 << CW));
    // R1 engine drains in order
    for (int i = 0; i < D; i++) begin
      @(negedge clk); #1;
      check("R9 out_valid", int'(eng_out_valid), 1);
      check("R1 order", int'(eng_out_data), 16'hA000 + i);
      eng_out_ready = 1;
      @(negedge clk); eng_out_ready = 0;
    end
    #1 check("R9 empty no valid", int'(eng_out_valid), 0);

    // card-to-host mode
    wr(2'd2, W'(16'h11));
    wr(2'd0, W'(16'hBEEF));
    peek(2'd3, v); check("R10 write ignored", fill_of(v), 0);
    rd(2'd0, v); check("R7 underrun value", int'(v), 0);
    peek(2'd3, v); check("R7 fill after underrun", fill_of(v), 0);
    peek(2'd1, v); check("R7 underrun err", int'(v[3]), 1);
    wr(2'd1, W'(8));
    for (int f = 0; f <= D; f++) begin
      for (int t = 0; t <= D; t++) begin
        wr(2'd3, W'((4 << WL) | (t << RL)));
        peek(2'd1, v);
        check("R4 flag", int'(v[0]), int'(f >= t));
        check("R6 irq", int'(data_irq), int'(f >= t));
      end
      peek(2'd3, v); check("R2 fill", fill_of(v), f);
      @(negedge clk); #1;
      check("R9 in_ready", int'(eng_in_ready), int'(f < D));
      if (f < D) begin
        eng_in_valid = 1; eng_in_data = W'(16'hB000 + f);
        @(negedge clk); eng_in_valid = 0;
      end
    end
    // offer when full: not taken
    eng_in_valid = 1; eng_in_data = W'(16'h5555);
    @(negedge clk); eng_in_valid = 0;
    peek(2'd3, v); check("R9 full blocks", fill_of(v), D);
    peek(2'd1, v); check("R9 no err", int'(v[3]), 0);
    for (int i = 0; i < D; i++) begin
      rd(2'd0, v); check("R1 read order", int'(v), 16'hB000 + i);
      peek(2'd3, v); check("R2 drain fill", fill_of(v), D - 1 - i);
    end
    peek(2'd1, v); check("R7 no err on valid reads", int'(v[3]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule